// File: doc/BRIEF.md
# Interrupt Moderation Timer Unit

This unit sits between a network controller's interrupt cause and mask logic and the interrupt output line. It spaces interrupts apart with one shared countdown timer. When a new interrupt edge arrives and no window is open, the line goes high at once and a moderation window opens. Any further edge that arrives while the window is open is held back until the window closes. When the window ends, the current pending vector is checked again. If causes are still pending, that check raises the line and can open the next window.

The length of the window is the smallest nonzero value among three candidates: a throttle setting, a receive absolute delay and a transmit absolute delay. The receive and transmit candidates count only under their own conditions. The window is counted in ticks of 256 ns, which a prescaler derives from the clock period. When moderation is disabled, the line simply follows whether any cause is pending.

Top module: `intr_moderator`

## Requirements
- R1: When no edge is being held back, `irq` on the clock edge after any cycle equals "pend is nonzero" in that cycle. When `irq` is high and `pend` becomes zero, `irq` drops one cycle later.
- R2: If `irq` is low, `pend` becomes nonzero and a window is open (moderation enabled), `irq` stays low until the window has ended.
- R3: If `irq` is low, `pend` becomes nonzero and no window is open, `irq` goes high on the next clock edge. In the same edge the window is armed with the chosen delay.
- R4: The chosen delay is the minimum over the qualifying candidates whose value is nonzero. A candidate whose value is zero is ignored. If no candidate is nonzero, no window opens and a following edge is passed at once.
- R5: The transmit candidate is 4 × the transmit delay register. It qualifies only if the descriptor-delay flag is set and `pend` bit 0 (descriptor written) or bit 1 (queue empty) is set.
- R6: The receive candidate is 4 × the receive absolute delay register. It qualifies only if the receive gate register is nonzero and `pend` bit 7 (receive timer) is set.
- R7: The throttle register is always a candidate. A delay of D ticks keeps the window open for D × TICK clock cycles, where TICK is 256 ns divided by the clock period. With the window armed in edge k, a held edge reaches `irq` in edge k + D×TICK + 1.
- R8: A write selects its register with `reg_sel`: 0 throttle, 1 receive gate, 2 receive absolute delay, 3 transmit delay. Only bits 15:0 of `reg_wdata` are stored.
- R9: The descriptor-delay flag is set by a `desc_done` pulse whose `desc_ide` is 1. It is cleared by every delay evaluation, whether or not a window was armed. A pulse with `desc_ide` at 0 does not set it.
- R10: When a window ends while causes are still pending, the released edge arms a new window. An edge that follows soon after is then held again.
- R11: With `mod_en` low, `irq` follows "pend is nonzero" one cycle later, and no window opens or stays open.
- R12: Synchronous reset drives `irq` low, closes the window, and clears the descriptor-delay flag and all four delay registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Moderation enable |
| pend | input | CAUSE_W | Masked pending cause vector (mask AND cause) |
| desc_done | input | 1 | Pulse: one transmit descriptor processed |
| desc_ide | input | 1 | Delay-request bit of that descriptor |
| reg_wr | input | 1 | Delay register write strobe |
| reg_sel | input | 2 | Register select (see R8) |
| reg_wdata | input | 32 | Write data; the low 16 bits are kept |
| irq | output | 1 | Registered interrupt line level |

## Verification
Assertions check on every cycle that edges are held while a window is open (R2), that an edge with no window open goes through in one cycle (R3), that the line follows the pending level otherwise (R1), and that the countdown moves only on prescaler ticks and stays in range (R7). They also check that a disabled unit never keeps a window open (R11). The actual window lengths can be seen only in the bench scenarios, which measure how many cycles pass before a held edge is released. Those lengths show which candidate won (R4 to R6), how the register selects and truncation behave (R8), the lifetime of the descriptor flag (R9), re-arming on expiry (R10) and the reset state (R12).

// File: rtl/imod_pkg.sv
package imod_pkg;
  localparam int REG_W = 16;
  localparam int CNT_W = REG_W + 2;

  typedef enum logic [1:0] {
    SEL_THROTTLE = 2'd0,
    SEL_RX_GATE  = 2'd1,
    SEL_RX_ABS   = 2'd2,
    SEL_TX_ABS   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [REG_W-1:0] throttle;
    logic [REG_W-1:0] rx_gate;
    logic [REG_W-1:0] rx_abs;
    logic [REG_W-1:0] tx_abs;
  } delay_regs_t;
endpackage

// File: rtl/imod_regs.sv
module imod_regs
  import imod_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output delay_regs_t      regs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr) begin
      unique case (reg_sel_e'(sel))
        SEL_THROTTLE: regs.throttle <= wdata;
        SEL_RX_GATE:  regs.rx_gate  <= wdata;
        SEL_RX_ABS:   regs.rx_abs   <= wdata;
        SEL_TX_ABS:   regs.tx_abs   <= wdata;
        default:      regs          <= regs;
      endcase
    end
  end
endmodule

// File: rtl/imod_delay_sel.sv
module imod_delay_sel
  import imod_pkg::*;
(
  input  delay_regs_t      regs,
  input  logic             ide_flag,
  input  logic             tx_cause,
  input  logic             rx_cause,
  output logic [CNT_W-1:0] delay
);
  localparam int NCAND = 3;

  logic [CNT_W-1:0] cand [NCAND];
  logic             qual [NCAND];

  // Candidate 0: throttle (always qualifies). 1: receive absolute. 2: transmit.
  assign cand[0] = {2'b00, regs.throttle};
  assign qual[0] = 1'b1;
  assign cand[1] = {regs.rx_abs, 2'b00};
  assign qual[1] = rx_cause && (regs.rx_gate != '0);
  assign cand[2] = {regs.tx_abs, 2'b00};
  assign qual[2] = tx_cause && ide_flag;

  always_comb begin
    delay = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (qual[i] && cand[i] != '0 && (delay == '0 || cand[i] < delay))
        delay = cand[i];
    end
  end
endmodule

// File: rtl/imod_timer.sv
module imod_timer #(
  parameter int CNT_W = 18,
  parameter int TICK  = 51
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             arm,
  input  logic [CNT_W-1:0] load,
  output logic             running
);
  localparam int PRE_W = (TICK > 1) ? $clog2(TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      running <= 1'b0;
      cnt_q   <= '0;
      pre_q   <= '0;
    end else if (arm) begin
      running <= 1'b1;
      cnt_q   <= load;
      pre_q   <= '0;
    end else if (running) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (cnt_q == CNT_W'(1)) begin
          running <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R7: the count moves only on a prescaler tick
  a_r7_count_on_tick: assert property (@(posedge clk) disable iff (rst)
    (running && !arm && !clr && pre_q != PRE_LAST) |=> $stable(cnt_q));
  // R7: a running window always has ticks left to count
  a_r7_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt_q != '0));
endmodule

// File: rtl/intr_moderator.sv
module intr_moderator
  import imod_pkg::*;
#(
  parameter int CAUSE_W       = 32,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int TXDW_BIT      = 0,
  parameter int TXQE_BIT      = 1,
  parameter int RXT_BIT       = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mod_en,
  input  logic [CAUSE_W-1:0] pend,
  input  logic               desc_done,
  input  logic               desc_ide,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic               irq
);
  localparam int TICK_RAW = (256000 + CLK_PERIOD_PS / 2) / CLK_PERIOD_PS;
  localparam int TICK     = (TICK_RAW < 1) ? 1 : TICK_RAW;

  delay_regs_t      regs;
  logic [CNT_W-1:0] delay;
  logic             running;
  logic             ide_q;
  logic             pend_any;
  logic             rise, hold, eval, arm;
  logic             ide_in;

  imod_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata[REG_W-1:0]),
    .regs  (regs)
  );

  imod_delay_sel u_sel (
    .regs     (regs),
    .ide_flag (ide_q),
    .tx_cause (pend[TXDW_BIT] | pend[TXQE_BIT]),
    .rx_cause (pend[RXT_BIT]),
    .delay    (delay)
  );

  imod_timer #(.CNT_W(CNT_W), .TICK(TICK)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (!mod_en),
    .arm     (arm),
    .load    (delay),
    .running (running)
  );

  assign pend_any = |pend;
  assign rise     = !irq && pend_any;
  assign hold     = rise && running && mod_en;
  assign eval     = rise && !running && mod_en;
  assign arm      = eval && (delay != '0);
  assign ide_in   = desc_done && desc_ide;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      ide_q <= 1'b0;
    end else begin
      irq   <= hold ? 1'b0 : pend_any;
      ide_q <= eval ? ide_in : (ide_q | ide_in);
    end
  end

  // R2: an edge inside an open window is held back
  a_r2_hold_in_window: assert property (@(posedge clk) disable iff (rst)
    (mod_en && running && !irq && pend_any) |=> !irq);
  // R3: with no window open, a new edge reaches the line in one cycle
  a_r3_first_passes: assert property (@(posedge clk) disable iff (rst)
    (!running && !irq && pend_any) |=> irq);
  // R1: outside a held edge the line tracks the pending level
  a_r1_follow: assert property (@(posedge clk) disable iff (rst)
    (irq || !running || !mod_en) |=> (irq == $past(pend_any)));
  // R11: a disabled unit keeps no window open
  a_r11_no_window_off: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> !running);
endmodule

// File: tb/intr_moderator_test.sv
`timescale 1ns/1ps
module intr_moderator_test;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        mod_en;
  logic [31:0] pend;
  logic        desc_done, desc_ide;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  intr_moderator #(.CLK_PERIOD_PS(64000)) uut (
    .clk(clk), .rst(rst), .mod_en(mod_en), .pend(pend),
    .desc_done(desc_done), .desc_ide(desc_ide),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe_desc(input logic ide);
    @(negedge clk);
    desc_done = 1'b1; desc_ide = ide;
    @(negedge clk);
    desc_done = 1'b0; desc_ide = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    pend = '0;
    repeat (n) @(posedge clk);
  endtask

  // Raise pend (edge k), drop it, raise again. Return how many edges after k
  // pass before irq is seen high again.
  task automatic measure(input string req, input logic [31:0] v, output int n);
    @(negedge clk);
    pend = v;
    @(posedge clk);
    @(negedge clk);
    chk({req, " first edge passes (R3)"}, int'(irq), 1);
    pend = '0;
    @(posedge clk);
    @(negedge clk);
    chk({req, " line drops (R1)"}, int'(irq), 0);
    pend = v;
    n = 1;
    for (int i = 0; i < 500; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic t_reset;
    int n;
    @(negedge clk);
    chk("R12 irq low after reset", int'(irq), 0);
    mod_en = 1'b1;
    measure("R12 regs cleared", 32'h8, n);
    chk("R12 no window with cleared regs", n, 2);
    idle(100);
  endtask

  task automatic t_disabled;
    int n;
    mod_en = 1'b0;
    wr(2'd0, 32'd10);
    measure("R11", 32'h8, n);
    chk("R11 disabled passes edges at once", n, 2);
    idle(100);
    mod_en = 1'b1;
  endtask

  task automatic t_throttle;
    int n;
    measure("R7", 32'h8, n);
    chk("R7 R2 throttle window 10 ticks", n, 10 * TICK + 1);
    idle(100);
  endtask

  task automatic t_rearm;
    int n;
    measure("R10", 32'h8, n);
    chk("R10 released edge", n, 10 * TICK + 1);
    @(negedge clk);
    pend = '0;
    @(posedge clk);
    @(negedge clk);
    pend = 32'h8;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 new window holds next edge", int'(irq), 0);
    idle(100);
  endtask

  task automatic t_trunc;
    int n;
    wr(2'd0, 32'h0005_0003);
    measure("R8", 32'h8, n);
    chk("R8 upper bits dropped", n, 3 * TICK + 1);
    idle(100);
    wr(2'd0, 32'd10);
  endtask

  task automatic t_rx;
    int n;
    wr(2'd1, 32'd1);
    wr(2'd2, 32'd2);
    measure("R6", 32'h80, n);
    chk("R6 R4 receive candidate smaller", n, 8 * TICK + 1);
    idle(100);
    wr(2'd1, 32'd0);
    measure("R6", 32'h80, n);
    chk("R6 gate zero ignores receive", n, 10 * TICK + 1);
    idle(100);
    wr(2'd1, 32'd1);
    wr(2'd2, 32'd0);
    measure("R4", 32'h80, n);
    chk("R4 zero candidate ignored", n, 10 * TICK + 1);
    idle(100);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_tx;
    int n;
    wr(2'd3, 32'd1);
    measure("R5", 32'h1, n);
    chk("R5 no flag ignores transmit", n, 10 * TICK + 1);
    idle(100);
    strobe_desc(1'b1);
    measure("R5", 32'h1, n);
    chk("R5 transmit candidate on bit0", n, 4 * TICK + 1);
    idle(100);
    measure("R9", 32'h2, n);
    chk("R9 flag cleared by evaluation", n, 10 * TICK + 1);
    idle(100);
    strobe_desc(1'b1);
    measure("R5", 32'h2, n);
    chk("R5 transmit candidate on bit1", n, 4 * TICK + 1);
    idle(100);
    strobe_desc(1'b0);
    measure("R9", 32'h1, n);
    chk("R9 pulse without bit leaves flag", n, 10 * TICK + 1);
    idle(100);
  endtask

  task automatic t_none;
    int n;
    wr(2'd0, 32'd0);
    measure("R4", 32'h8, n);
    chk("R4 no candidate no window", n, 2);
    idle(100);
  endtask

  task automatic t_reset_flag;
    int n;
    strobe_desc(1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr(2'd0, 32'd10);
    wr(2'd3, 32'd1);
    measure("R12", 32'h1, n);
    chk("R12 reset clears flag", n, 10 * TICK + 1);
    idle(100);
  endtask

  initial begin
    rst = 1'b1; mod_en = 1'b0; pend = '0;
    desc_done = 1'b0; desc_ide = 1'b0;
    reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_throttle();
    t_rearm();
    t_trunc();
    t_rx();
    t_tx();
    t_none();
    t_reset_flag();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule